// File: doc/BRIEF.md
# Programmable Peripheral Bus Cycle Timer

This block turns a host-side transfer request into the pin activity of one cycle on a narrow peripheral bus. Once a request is accepted, a counter starts at a reference cycle, which is the second clock after the accepted request. Every pin edge is placed at a programmed offset from that cycle. The offsets are 4-bit values and are supplied as one 32-bit timing word. The edges covered are chip-select on and off, strobe on and off, the release of write data, and the release and re-drive of the data bus around a read.

Two strobe styles are available. In the first, separate read and write strobes are used. In the second, a single data strobe is used together with a read-not-write line. An idle-mode field sets whether the data pins stay driven between cycles or float. While configuration is being loaded from external memory, the data pins are held undriven. A timing word with an impossible chip-select order raises an error flag and stops cycles from starting. A busy output holds off new requests, and a one-cycle done pulse marks the end of each cycle.

Top module: `lbus_cycle_timer`

## Requirements
- R1: The timing word `tim_i` holds eight 4-bit fields. From bit 31 downward they are: cs_on, cs_off, stb_on, stb_off, wr_rel, rd_rel, rd_redrive and idle_mode. A request is accepted when all of these hold at a clock edge: `req_i` is high, `busy_o` is low, `cfg_load_i` is low and the word is legal. Offset 0 (the reference cycle) is the second clock after that edge. From offset 0 until the cycle ends, `lb_addr_oe_o` is high and `lb_addr_o` shows the accepted address.
- R2: `lb_cs_n_o` is low exactly in the offsets k where cs_on <= k < cs_off.
- R3: When `style_i` is 0 at acceptance, one strobe is active in the offsets stb_on <= k < stb_off. On a read that strobe is `lb_rd_n_o`, and on a write it is `lb_wr_n_o`. The other strobe stays high, and `lb_rnw_o` stays high.
- R4: When `style_i` is 1, `lb_rd_n_o` is the strobe for both directions over the same window, and `lb_wr_n_o` stays high. On a write, `lb_rnw_o` is low from offset 0 to the end of the cycle. On a read, `lb_rnw_o` stays high throughout.
- R5: On a write, `lb_data_o` carries the accepted write data from offset 0. When idle_mode is not 0xF, `lb_data_oe_o` is high only for offsets k < wr_rel.
- R6: When idle_mode is 0xF, `lb_data_oe_o` is high while the bus is idle and for the whole of a write. During a read it is low only in the offsets rd_rel <= k < rd_redrive.
- R7: When idle_mode is not 0xF, `lb_data_oe_o` is low while the bus is idle and for the whole of a read, whatever values rd_rel and rd_redrive hold.
- R8: While `cfg_load_i` is high, `lb_data_oe_o` is low and requests are not accepted.
- R9: `err_o` is high when cs_on > cs_off or cs_on > stb_on. A request made while `err_o` is high is not accepted.
- R10: The last offset is the largest of cs_off, stb_off and one direction-dependent term. For a write that term is wr_rel. For a read it is rd_redrive when idle_mode is 0xF, and 0 otherwise. `done_o` is high for exactly the one cycle at the last offset, and the bus is idle in the cycle after it.
- R11: `busy_o` is high from the clock after acceptance through the done cycle. A request raised while `busy_o` is high is ignored, and the running cycle keeps its timing.
- R12: On a read, `rdata_o` captures `lb_data_i` at the clock edge that ends offset stb_off-1, and holds that value until the next capture.
- R13: After reset the block is idle with `busy_o`=0, `done_o`=0, `lb_addr_oe_o`=0 and all active-low pins and `lb_rnw_o` high. The default timing word `TIM_DEFAULT` (0x0413_404F) gives one clock of setup before the strobe, a two-clock strobe, one clock of chip-select hold, and a last offset of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Configuration load in progress |
| req_i | input | 1 | Host transfer request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Write data |
| style_i | input | 1 | 0 = separate strobes, 1 = single strobe with read-not-write |
| tim_i | input | 32 | Packed timing word |
| lb_data_i | input | DW | Data bus input |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Last offset of the cycle |
| err_o | output | 1 | Timing word is illegal |
| rdata_o | output | DW | Captured read data |
| lb_addr_o | output | AW | Bus address |
| lb_addr_oe_o | output | 1 | Address drive enable |
| lb_cs_n_o | output | 1 | Chip select, active low |
| lb_rd_n_o | output | 1 | Read strobe, or the single data strobe |
| lb_wr_n_o | output | 1 | Write strobe, active low |
| lb_rnw_o | output | 1 | Read-not-write |
| lb_data_o | output | DW | Data bus output |
| lb_data_oe_o | output | 1 | Data drive enable |

## Verification
The bench uses the default 8-bit address and data widths, so every timing field keeps its full 4-bit range. It sweeps chip-select start, setup, strobe length and hold over a grid. Each point of the grid is run in both strobe styles, both directions and both idle modes. Every pin is compared at every offset against values the bench works out from the field arithmetic. Further runs cover the default timing word, both illegal orderings, configuration loading and a request held high through a running cycle.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
    localparam int TW = 4;
    localparam int NFIELD = 8;
    localparam int TIMW = TW * NFIELD;

    typedef logic [TW-1:0] ofs_t;

    typedef struct packed {
        ofs_t cs_on;
        ofs_t cs_off;
        ofs_t st_on;
        ofs_t st_off;
        ofs_t wr_rel;
        ofs_t rd_rel;
        ofs_t rd_drv;
        ofs_t idle;
    } tim_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} phase_t;

    localparam ofs_t IDLE_DRIVE = '1;

    localparam tim_t TIM_DEFAULT = '{cs_on: 4'd0, cs_off: 4'd4, st_on: 4'd1, st_off: 4'd3,
                                     wr_rel: 4'd4, rd_rel: 4'd0, rd_drv: 4'd4, idle: 4'hF};

    function automatic logic in_win(ofs_t c, ofs_t on, ofs_t off);
        return (c >= on) && (c < off);
    endfunction

    function automatic ofs_t max2(ofs_t a, ofs_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic tim_bad(tim_t t);
        return (t.cs_on > t.cs_off) || (t.cs_on > t.st_on);
    endfunction

    function automatic ofs_t last_edge(tim_t t, logic wr);
        ofs_t dir_term;
        if (wr)                      dir_term = t.wr_rel;
        else if (t.idle == IDLE_DRIVE) dir_term = t.rd_drv;
        else                         dir_term = '0;
        return max2(max2(t.cs_off, t.st_off), dir_term);
    endfunction
endpackage

// File: rtl/lbt_seq.sv
module lbt_seq
    import lbt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  ofs_t   last_i,
    output phase_t phase_o,
    output ofs_t   cnt_o,
    output logic   done_o
);
    phase_t phase_q;
    ofs_t   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                ST_IDLE: if (start_i) phase_q <= ST_ARM;
                ST_ARM: begin
                    phase_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    if (cnt_q == last_i) phase_q <= ST_IDLE;
                    else                 cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;
    assign done_o  = (phase_q == ST_RUN) && (cnt_q == last_i);

    // R1: one arming clock, then the reference cycle at offset 0
    assert_ref_after_arm_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_ARM) |=> (phase_q == ST_RUN && cnt_q == '0));

    // R10: the counter steps by one until it reaches the last offset
    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_RUN && cnt_q != last_i) |=> (phase_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

    // R10: the bus is idle after the done cycle
    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (phase_q == ST_IDLE));
endmodule

// File: rtl/lbt_pins.sv
module lbt_pins
    import lbt_pkg::*;
(
    input  phase_t phase_i,
    input  ofs_t   cnt_i,
    input  tim_t   tim_i,
    input  logic   wr_i,
    input  logic   style_i,
    input  ofs_t   live_idle_i,
    input  logic   cfg_load_i,
    output logic   cs_n_o,
    output logic   rd_n_o,
    output logic   wr_n_o,
    output logic   rnw_o,
    output logic   addr_oe_o,
    output logic   data_oe_o
);
    logic run, stb, drive_idle;

    always_comb begin
        run        = (phase_i == ST_RUN);
        stb        = run && in_win(cnt_i, tim_i.st_on, tim_i.st_off);
        drive_idle = ((phase_i == ST_IDLE) ? live_idle_i : tim_i.idle) == IDLE_DRIVE;

        cs_n_o    = !(run && in_win(cnt_i, tim_i.cs_on, tim_i.cs_off));
        addr_oe_o = run;

        if (style_i) begin
            rd_n_o = !stb;
            wr_n_o = 1'b1;
            rnw_o  = !(run && wr_i);
        end else begin
            rd_n_o = !(stb && !wr_i);
            wr_n_o = !(stb && wr_i);
            rnw_o  = 1'b1;
        end

        if (cfg_load_i)
            data_oe_o = 1'b0;
        else if (run && wr_i)
            data_oe_o = drive_idle || (cnt_i < tim_i.wr_rel);
        else if (run)
            data_oe_o = drive_idle && !in_win(cnt_i, tim_i.rd_rel, tim_i.rd_drv);
        else
            data_oe_o = drive_idle;
    end
endmodule

// File: rtl/lbus_cycle_timer.sv
module lbus_cycle_timer
    import lbt_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load_i,
    input  logic            req_i,
    input  logic            req_wr_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic            style_i,
    input  logic [TIMW-1:0] tim_i,
    input  logic [DW-1:0]   lb_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic [DW-1:0]   rdata_o,
    output logic [AW-1:0]   lb_addr_o,
    output logic            lb_addr_oe_o,
    output logic            lb_cs_n_o,
    output logic            lb_rd_n_o,
    output logic            lb_wr_n_o,
    output logic            lb_rnw_o,
    output logic [DW-1:0]   lb_data_o,
    output logic            lb_data_oe_o
);
    tim_t          live_tim, job_tim;
    logic          job_wr, job_style, accept;
    logic [AW-1:0] job_addr;
    logic [DW-1:0] job_wdata, rdata_q;
    phase_t        phase;
    ofs_t          cnt, last;
    logic          capture;

    assign live_tim = tim_t'(tim_i);
    assign err_o    = tim_bad(live_tim);
    assign busy_o   = (phase != ST_IDLE);
    assign accept   = req_i && !busy_o && !cfg_load_i && !err_o;
    assign last     = last_edge(job_tim, job_wr);
    assign capture  = (phase == ST_RUN) && !job_wr &&
                      ((TW+1)'(cnt) + (TW+1)'(1) == (TW+1)'(job_tim.st_off));

    always_ff @(posedge clk) begin
        if (rst) begin
            job_tim   <= TIM_DEFAULT;
            job_wr    <= 1'b0;
            job_style <= 1'b0;
            job_addr  <= '0;
            job_wdata <= '0;
        end else if (accept) begin
            job_tim   <= live_tim;
            job_wr    <= req_wr_i;
            job_style <= style_i;
            job_addr  <= req_addr_i;
            job_wdata <= req_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= lb_data_i;
    end

    lbt_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept),
        .last_i  (last),
        .phase_o (phase),
        .cnt_o   (cnt),
        .done_o  (done_o)
    );

    lbt_pins u_pins (
        .phase_i     (phase),
        .cnt_i       (cnt),
        .tim_i       (job_tim),
        .wr_i        (job_wr),
        .style_i     (job_style),
        .live_idle_i (live_tim.idle),
        .cfg_load_i  (cfg_load_i),
        .cs_n_o      (lb_cs_n_o),
        .rd_n_o      (lb_rd_n_o),
        .wr_n_o      (lb_wr_n_o),
        .rnw_o       (lb_rnw_o),
        .addr_oe_o   (lb_addr_oe_o),
        .data_oe_o   (lb_data_oe_o)
    );

    assign rdata_o   = rdata_q;
    assign lb_addr_o = job_addr;
    assign lb_data_o = job_wdata;

    // R8: no data drive while configuration loads
    assert_cfg_float_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_load_i |-> !lb_data_oe_o);

    // R9: an illegal word never starts a cycle
    assert_bad_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (req_i && err_o && !busy_o) |=> !busy_o);

    // R2: chip select only while the address is driven
    assert_cs_has_addr_R2: assert property (@(posedge clk) disable iff (rst)
        !lb_cs_n_o |-> lb_addr_oe_o);

    // R11: a running cycle is not cut short by a new request
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R10: done lasts one cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/tb_lbus_cycle_timer.sv
module tb_lbus_cycle_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load, req, req_wr, style;
    logic [7:0]  req_addr, req_wdata, lb_din;
    logic [31:0] tim;
    logic        busy, done, err, addr_oe, cs_n, rd_n, wr_n, rnw, data_oe;
    logic [7:0]  rdata, lb_addr, lb_dout;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lbus_cycle_timer dut (
        .clk(clk), .rst(rst), .cfg_load_i(cfg_load), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .style_i(style), .tim_i(tim),
        .lb_data_i(lb_din), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
        .lb_addr_o(lb_addr), .lb_addr_oe_o(addr_oe), .lb_cs_n_o(cs_n), .lb_rd_n_o(rd_n),
        .lb_wr_n_o(wr_n), .lb_rnw_o(rnw), .lb_data_o(lb_dout), .lb_data_oe_o(data_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int a, int b, int c, int d, int e, int f, int g, int h);
        return {a[3:0], b[3:0], c[3:0], d[3:0], e[3:0], f[3:0], g[3:0], h[3:0]};
    endfunction

    function automatic logic [7:0] busval(int k);
        return 8'h5A ^ k[7:0];
    endfunction

    // one full cycle with per-offset comparison; hold keeps req high while busy
    task automatic run_one(input logic [31:0] t, input logic w, input logic s,
                           input logic [7:0] a, input logic [7:0] d, input logic hold);
        int cs_on, cs_off, st_on, st_off, wr_rel, rd_rel, rd_drv, last;
        logic idle_f, stb;
        cs_on = t[31:28]; cs_off = t[27:24]; st_on = t[23:20]; st_off = t[19:16];
        wr_rel = t[15:12]; rd_rel = t[11:8]; rd_drv = t[7:4]; idle_f = (t[3:0] == 4'hF);
        last = (cs_off > st_off) ? cs_off : st_off;
        if (w && wr_rel > last) last = wr_rel;
        if (!w && idle_f && rd_drv > last) last = rd_drv;

        @(negedge clk);
        req = 1'b1; req_wr = w; style = s; tim = t; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (!hold) req = 1'b0;
        req_wdata = ~d;
        chk("R11 busy after accept", busy, 1);
        chk("R1 no address before reference", addr_oe, 0);
        chk("R6/R7 arm data_oe", data_oe, idle_f);
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            lb_din = busval(k);
            if (k == last) req = 1'b0;
            stb = (k >= st_on) && (k < st_off);
            chk("R1 addr_oe", addr_oe, 1);
            chk("R1 addr", lb_addr, a);
            chk("R2 cs_n", cs_n, !((k >= cs_on) && (k < cs_off)));
            if (s) begin
                chk("R4 single strobe", rd_n, !stb);
                chk("R4 wr_n idle", wr_n, 1);
                chk("R4 rnw", rnw, !w);
            end else begin
                chk("R3 rd_n", rd_n, !(stb && !w));
                chk("R3 wr_n", wr_n, !(stb && w));
                chk("R3 rnw high", rnw, 1);
            end
            if (w) begin
                chk(idle_f ? "R6 write oe" : "R5 write oe", data_oe, idle_f || (k < wr_rel));
                chk("R5 write data", lb_dout, d);
            end else if (idle_f) begin
                chk("R6 read turnaround", data_oe, !((k >= rd_rel) && (k < rd_drv)));
            end else begin
                chk("R7 read float", data_oe, 0);
            end
            chk("R10 done", done, k == last);
            chk("R11 busy", busy, 1);
        end
        @(negedge clk);
        chk("R10 idle after done", busy, 0);
        chk("R10 done low", done, 0);
        chk("R6/R7 idle oe", data_oe, idle_f);
        if (!w && st_off >= 1) chk("R12 read capture", rdata, busval(st_off - 1));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog R1..R13 run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_load = 1'b0; req = 1'b0; req_wr = 1'b0; style = 1'b0;
        req_addr = '0; req_wdata = '0; lb_din = '0; tim = 32'h0413_404F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 reset busy", busy, 0);
        chk("R13 reset done", done, 0);
        chk("R13 reset addr_oe", addr_oe, 0);
        chk("R13 reset cs_n", cs_n, 1);
        chk("R13 reset rd_n", rd_n, 1);
        chk("R13 reset wr_n", wr_n, 1);
        chk("R13 reset rnw", rnw, 1);

        // R13: default timing word, both directions and styles
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
                run_one(32'h0413_404F, w[0], s[0], 8'h3C, 8'hC3, 1'b0);

        // grid sweep
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 2; w++)
            for (int im = 0; im < 2; im++)
              for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                  for (int len = 1; len < 4; len++)
                    for (int h = 0; h < 2; h++) begin
                        int st_on, st_off;
                        st_on  = a + b;
                        st_off = st_on + len;
                        run_one(mk(a, st_off + h, st_on, st_off, st_off + (b % 2), st_on,
                                   st_off + h, im ? 15 : a * 3),
                                w[0], s[0], 8'(a * 16 + b * 4 + len), 8'(len * 37 + h), 1'b0);
                    end

        // R11: request held high through a running cycle
        run_one(mk(1, 6, 2, 5, 6, 2, 6, 15), 1'b1, 1'b0, 8'h77, 8'h99, 1'b1);
        run_one(mk(0, 3, 1, 2, 3, 1, 3, 4), 1'b0, 1'b1, 8'h11, 8'h22, 1'b1);

        // R9: cs_on later than cs_off
        @(negedge clk);
        tim = mk(3, 2, 4, 5, 5, 0, 5, 15); req = 1'b1;
        #1 chk("R9 err cs order", err, 1);
        @(negedge clk);
        chk("R9 no start cs order", busy, 0);
        // R9: cs_on later than strobe on
        tim = mk(3, 6, 2, 5, 5, 0, 5, 15);
        #1 chk("R9 err strobe order", err, 1);
        @(negedge clk);
        chk("R9 no start strobe order", busy, 0);
        req = 1'b0;
        tim = 32'h0413_404F;
        #1 chk("R9 err clear on legal word", err, 0);

        // R8: configuration loading
        @(negedge clk);
        cfg_load = 1'b1; req = 1'b1;
        #1 chk("R8 oe low while loading", data_oe, 0);
        @(negedge clk);
        chk("R8 no start while loading", busy, 0);
        chk("R8 oe still low", data_oe, 0);
        req = 1'b0; cfg_load = 1'b0;
        #1 chk("R6 idle drive after load", data_oe, 1);
        tim = mk(0, 4, 1, 3, 4, 0, 4, 5);
        #1 chk("R7 idle float", data_oe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule